// File: doc/BRIEF.md
# Supervisory Watchdog with Failsafe Boot Select

This block is the watchdog timer of a small board management controller. A host reaches it through a byte-wide register port with a write strobe, a read strobe, an 8-bit offset and 8-bit data. The host sets a reload value in whole seconds. It then arms the timer in one of two modes, normal or recovery, and keeps it alive by writing a magic byte to a kick register. A prescaler turns the clock into one-second ticks. The countdown runs on those ticks while either mode is armed.

When the count runs out, the block can raise two outputs. One is a fixed-length system reset request. The other is a separate timeout line. If recovery mode was armed at that moment, it also latches a failsafe boot select, which tells the boot logic to start the recovery image. A lock bit freezes the configuration until the next reset. A strap input can arm the watchdog in recovery mode as the block leaves reset, so a bootloader that hangs is caught.

Top module: `board_wdt`

## Requirements
- R1: After reset every output is low, the control register reads 0x00 (strap low) and the timeout register reads DEF_TIMEOUT. A read strobe returns data on rdata_o one cycle later. Offset 0x00 is control, 0x01 is timeout and 0x02 is kick. Reads of the kick offset and of control bits 3..5 return 0.
- R2: Control bit 0 arms normal mode and bit 1 arms recovery mode. A write with both bits set stores recovery only. A control write with both bits clear stops the countdown, and no expiry follows.
- R3: A write of exactly 0x6B to offset 0x02 reloads the count from the timeout register and restarts the seconds prescaler. A write of any other value there has no effect on the count.
- R4: With timeout T armed after a kick, the expiry outputs rise T*CLK_HZ+1 cycles after the clock edge that stored the arming control write, and not earlier.
- R5: With timeout 0, a kick followed by an arming write makes the expiry outputs rise one cycle after the arming edge.
- R6: On expiry, sys_rst_o is high for exactly PULSE_LEN cycles if control bit 6 was set, and wdt_to_o is high for the same window if bit 7 was set. Expiry clears both enable bits and leaves bits 2, 6 and 7 as they were.
- R7: An expiry in recovery mode sets failsafe_o, which stays high until rst_ni. An expiry in normal mode leaves it low.
- R8: Once control bit 2 (lock) is set, writes to control and timeout are ignored until rst_ni, while kicks are still accepted.
- R9: With guard_i high during reset, the first cycle after reset loads control with 0x42 (recovery, reset action), and the countdown starts from DEF_TIMEOUT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| guard_i | input | 1 | Nonvolatile strap: arm recovery mode at reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after rd_i |
| sys_rst_o | output | 1 | System reset request pulse |
| wdt_to_o | output | 1 | Timeout line pulse |
| failsafe_o | output | 1 | Failsafe boot image select |

## Verification
The bench builds the block with CLK_HZ = 10, PULSE_LEN = 4 and DEF_TIMEOUT = 3. A "second" therefore lasts ten cycles, so a two-second countdown, a mid-count kick, a locked run and a strap-armed boot each fit in a few dozen cycles. Expiry can then be checked at its exact cycle rather than within a window. The short pulse length lets the bench measure both expiry pulses in full and then see failsafe_o stay high after they end.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_TMO    = 8'h01;
  localparam logic [7:0] OFS_KICK   = 8'h02;
  localparam logic [7:0] KICK_MAGIC = 8'h6B;

  typedef struct packed {
    logic act_to;
    logic act_rst;
    logic lock;
    logic en_rec;
    logic en_norm;
  } wdt_ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(wdt_ctrl_t c);
    return {c.act_to, c.act_rst, 3'b000, c.lock, c.en_rec, c.en_norm};
  endfunction

  function automatic wdt_ctrl_t byte_to_ctrl(logic [7:0] b);
    wdt_ctrl_t c;
    c.act_to  = b[7];
    c.act_rst = b[6];
    c.lock    = b[2];
    c.en_rec  = b[1];
    c.en_norm = b[0] & ~b[1];  // recovery wins when both are set
    return c;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEF_TIMEOUT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              guard_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output wdt_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] tmo_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] TMO_RST = DATA_W'(DEF_TIMEOUT);

  logic              init_q;
  wdt_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] tmo_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ok;

  assign wr_ok  = wr_i && init_q && !ctrl_q.lock;
  assign kick_o = wr_i && init_q && (addr_i == OFS_KICK) && (wdata_i == KICK_MAGIC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      ctrl_q <= '0;
    end else if (!init_q) begin
      init_q <= 1'b1;
      if (guard_i) begin
        ctrl_q.en_rec  <= 1'b1;
        ctrl_q.act_rst <= 1'b1;
      end
    end else if (expire_i) begin
      ctrl_q.en_norm <= 1'b0;
      ctrl_q.en_rec  <= 1'b0;
    end else if (wr_ok && addr_i == OFS_CTRL) begin
      ctrl_q <= byte_to_ctrl(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           tmo_q <= TMO_RST;
    else if (wr_ok && addr_i == OFS_TMO)   tmo_q <= wdata_i;
  end

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rd_mux = ctrl_to_byte(ctrl_q);
      OFS_TMO:  rd_mux = tmo_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign ctrl_o  = ctrl_q;
  assign tmo_o   = tmo_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int CLK_HZ = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pre_q <= '0;
    else if (restart_i || !run_i)   pre_q <= '0;
    else if (pre_q == LAST)         pre_q <= '0;
    else                            pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEF_TIMEOUT = 10,
  parameter int PULSE_LEN   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wdt_ctrl_t         ctrl_i,
  input  logic [DATA_W-1:0] tmo_i,
  input  logic              kick_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic              expire_o,
  output logic              sys_rst_o,
  output logic              wdt_to_o,
  output logic              failsafe_o
);
  localparam int LW = $clog2(PULSE_LEN + 1);
  localparam logic [LW-1:0]     PLEN    = LW'(PULSE_LEN);
  localparam logic [DATA_W-1:0] CNT_RST = DATA_W'(DEF_TIMEOUT);

  logic [DATA_W-1:0] cnt_q;
  logic [LW-1:0]     pls_q;
  logic              rst_act_q, to_act_q, fs_q;

  assign run_o    = ctrl_i.en_norm | ctrl_i.en_rec;
  assign expire_o = run_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= CNT_RST;
    else if (kick_i)                           cnt_q <= tmo_i;
    else if (run_o && tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pls_q     <= '0;
      rst_act_q <= 1'b0;
      to_act_q  <= 1'b0;
      fs_q      <= 1'b0;
    end else if (expire_o) begin
      pls_q     <= PLEN;
      rst_act_q <= ctrl_i.act_rst;
      to_act_q  <= ctrl_i.act_to;
      if (ctrl_i.en_rec) fs_q <= 1'b1;
    end else if (pls_q != '0) begin
      pls_q <= pls_q - 1'b1;
    end
  end

  assign sys_rst_o  = (pls_q != '0) && rst_act_q;
  assign wdt_to_o   = (pls_q != '0) && to_act_q;
  assign failsafe_o = fs_q;
endmodule

// File: rtl/board_wdt.sv
module board_wdt
  import wdt_pkg::*;
#(
  parameter int CLK_HZ      = 25_000_000,
  parameter int PULSE_LEN   = 16,
  parameter int DEF_TIMEOUT = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       guard_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sys_rst_o,
  output logic       wdt_to_o,
  output logic       failsafe_o
);
  localparam int DATA_W = 8;

  wdt_ctrl_t         ctrl;
  logic [DATA_W-1:0] tmo;
  logic              kick, tick, run, expire;
  logic              en_norm, en_rec, lock;

  assign en_norm = ctrl.en_norm;
  assign en_rec  = ctrl.en_rec;
  assign lock    = ctrl.lock;

  wdt_regs #(.DATA_W(DATA_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
    .clk_i, .rst_ni, .guard_i, .wr_i, .rd_i, .addr_i, .wdata_i,
    .expire_i(expire), .ctrl_o(ctrl), .tmo_o(tmo), .kick_o(kick), .rdata_o
  );

  wdt_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .restart_i(kick), .tick_o(tick)
  );

  wdt_core #(.DATA_W(DATA_W), .DEF_TIMEOUT(DEF_TIMEOUT), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .tmo_i(tmo), .kick_i(kick), .tick_i(tick),
    .run_o(run), .expire_o(expire), .sys_rst_o, .wdt_to_o, .failsafe_o
  );
endmodule

// File: rtl/board_wdt_chk.sv
module board_wdt_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic [7:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       sys_rst_o,
  input logic       failsafe_o,
  input logic       en_norm,
  input logic       en_rec,
  input logic       lock
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (sys_rst_o) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  p_pulse_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= 16'(PULSE_LEN));

  p_pulse_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> hi_cnt == 16'(PULSE_LEN));

  p_failsafe_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_o |=> failsafe_o);

  p_failsafe_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(failsafe_o) |-> $past(en_rec));

  p_one_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en_norm, en_rec}));

  p_lock_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> lock);

  p_kick_reads_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'h02) |=> rdata_o == 8'h00);
endmodule

bind board_wdt board_wdt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .sys_rst_o(sys_rst_o), .failsafe_o(failsafe_o),
  .en_norm(en_norm), .en_rec(en_rec), .lock(lock)
);

// File: tb/tb_board_wdt.sv
module tb_board_wdt;
  localparam int DIV  = 10;
  localparam int PLEN = 4;
  localparam int DEFT = 3;

  logic       clk_i = 1'b0, rst_ni = 1'b0, guard_i = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [7:0] rdata_o;
  logic       sys_rst_o, wdt_to_o, failsafe_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  board_wdt #(.CLK_HZ(DIV), .PULSE_LEN(PLEN), .DEF_TIMEOUT(DEFT)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_i = 1'b1; addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic do_reset(input logic g);
    guard_i = g; rst_ni = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset(1'b0);
    cyc(1);
    chk("R1 outputs idle", {sys_rst_o, wdt_to_o, failsafe_o}, 0);
    rd(8'h00, d); chk("R1 ctrl reset", d, 8'h00);
    rd(8'h01, d); chk("R1 timeout reset", d, DEFT);
    wr(8'h01, 8'h5A);
    rd(8'h01, d); chk("R1 timeout readback", d, 8'h5A);
    rd(8'h02, d); chk("R1 kick reads zero", d, 8'h00);
  endtask

  task automatic t_modes();
    logic [7:0] d;
    wr(8'h00, 8'hFB);  // both enables, lock clear, bits 3..5 set
    rd(8'h00, d); chk("R2 both enables -> recovery, R1 spare bits zero", d, 8'hC2);
    wr(8'h00, 8'h00);
    rd(8'h00, d); chk("R2 disable readback", d, 8'h00);
    wr(8'h01, 8'd1); wr(8'h02, 8'h6B); wr(8'h00, 8'h41);
    cyc(5);
    wr(8'h00, 8'h40);
    begin
      int hits = 0;
      for (int i = 0; i < 40; i++) begin cyc(1); if (sys_rst_o) hits++; end
      chk("R2 stopped watchdog never expires", hits, 0);
    end
  endtask

  task automatic t_countdown();
    logic [7:0] d;
    int hi;
    wr(8'h01, 8'd2); wr(8'h02, 8'h6B); wr(8'h00, 8'h41);
    cyc(2*DIV);
    chk("R4 no expiry before deadline", sys_rst_o, 0);
    cyc(1);
    chk("R4 expiry at deadline", sys_rst_o, 1);
    chk("R7 normal mode leaves failsafe low", failsafe_o, 0);
    chk("R6 timeout line off when bit7 clear", wdt_to_o, 0);
    hi = 1;
    for (int i = 0; i < PLEN + 2; i++) begin cyc(1); if (sys_rst_o) hi++; end
    chk("R6 reset pulse length", hi, PLEN);
    rd(8'h00, d); chk("R6 expiry clears enables", d, 8'h40);
  endtask

  task automatic t_kick();
    wr(8'h01, 8'd2); wr(8'h02, 8'h6B); wr(8'h00, 8'h41);
    cyc(15);
    wr(8'h02, 8'h6B);
    cyc(2*DIV);
    chk("R3 kick postpones expiry", sys_rst_o, 0);
    cyc(1);
    chk("R3 expiry after reload", sys_rst_o, 1);
    cyc(PLEN + 2);
    wr(8'h01, 8'd2); wr(8'h02, 8'h6B); wr(8'h00, 8'h41);
    cyc(5);
    wr(8'h02, 8'h6A);
    cyc(2*DIV - 6);
    chk("R3 wrong kick value ignored (no early)", sys_rst_o, 0);
    cyc(1);
    chk("R3 wrong kick value ignored (on time)", sys_rst_o, 1);
    cyc(PLEN + 2);
  endtask

  task automatic t_expire_now();
    wr(8'h01, 8'd0); wr(8'h02, 8'h6B); wr(8'h00, 8'h82);
    chk("R5 not before arming edge+1", wdt_to_o, 0);
    cyc(1);
    chk("R5 immediate expiry on timeout line", wdt_to_o, 1);
    chk("R6 reset request off when bit6 clear", sys_rst_o, 0);
    chk("R7 recovery expiry sets failsafe", failsafe_o, 1);
    cyc(3*PLEN);
    chk("R7 failsafe held after pulse", failsafe_o, 1);
    do_reset(1'b0);
    cyc(1);
    chk("R7 failsafe cleared by reset", failsafe_o, 0);
  endtask

  task automatic t_lock();
    logic [7:0] d1, d2, d3;
    wr(8'h01, 8'd2); wr(8'h02, 8'h6B); wr(8'h00, 8'h45);
    wr(8'h00, 8'h00);
    wr(8'h01, 8'd9);
    rd(8'h00, d1); rd(8'h01, d2);
    chk("R8 locked ctrl write ignored", d1, 8'h45);
    chk("R8 locked timeout write ignored", d2, 8'd2);
    wr(8'h02, 8'h6B);
    cyc(2*DIV);
    chk("R8 kick accepted while locked (no early)", sys_rst_o, 0);
    cyc(1);
    chk("R8 kick accepted while locked (on time)", sys_rst_o, 1);
    cyc(PLEN + 2);
    rd(8'h00, d3); chk("R8 lock survives expiry", d3, 8'h44);
    do_reset(1'b0);
    cyc(1);
    rd(8'h00, d3); chk("R8 lock cleared by reset", d3, 8'h00);
  endtask

  task automatic t_guard();
    logic [7:0] d;
    guard_i = 1'b1; rst_ni = 1'b0;
    cyc(3);
    rst_ni = 1'b1;      // next posedge is the init cycle
    @(posedge clk_i);
    rd(8'h00, d);
    chk("R9 strap arms recovery", d, 8'h42);
    cyc(DEFT*DIV - 1);
    chk("R9 no early expiry", failsafe_o, 0);
    cyc(1);
    chk("R9 strap expiry failsafe", failsafe_o, 1);
    chk("R9 strap expiry reset request", sys_rst_o, 1);
    cyc(PLEN + 2);
    do_reset(1'b0);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_countdown();
    t_kick();
    t_expire_now();
    t_lock();
    t_guard();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule